// File: doc/BRIEF.md
# Metastability Event Counting Harness

This block measures how often a register that samples an asynchronous input settles late. A launch register takes the asynchronous input on the rising clock edge. One downstream register takes the launch output on that same rising edge. A catching register takes it half a period later, on the falling edge. In a real device, a launch output that has not settled within half a period can be caught differently by the two paths. Once both samples are aligned to the rising edge, any difference between them is reported as an event.

The registered compare result is driven out as an observation pin. A saturating counter adds up the events while a measurement window is open. A free-running timer sets the window length, which defaults to 2^30 cycles (about a billion). When the window closes, a sticky done flag rises and the count holds until reset.

A clean register model never settles late, so the block has a test input that inverts the value the catching register stores. This produces a known disagreement on chosen cycles.

Top module: `metastab_harness`

## Requirements
- R1: While `force_flip` is held low, toggling `data_async` at any rate produces no events: `obs_event` stays 0 and `event_count` does not change.
- R2: When `force_flip` is high at a falling clock edge, the catching register stores the inverse of the launch output, and exactly one event results for each such falling edge.
- R3: `obs_event` is a registered compare result. For `force_flip` driven high between rising edges k and k+1, it is 1 after rising edge k+2 and is 0 again after edge k+3 if no further force follows.
- R4: `event_count` (default width 20 bits) increases by exactly one on the rising edge after each cycle in which `obs_event` is 1 and the window is open. Otherwise it keeps its value.
- R5: `event_count` saturates at its all-ones value and never wraps to zero.
- R6: The window is open for exactly `WINDOW_LEN` rising edges after reset release (default 2^30, with a 30-bit timer). An event that reaches the counter on edge `WINDOW_LEN` is counted, and one that reaches it on edge `WINDOW_LEN`+1 is not.
- R7: `window_done` is 0 before edge `WINDOW_LEN` after reset release, is 1 from that edge on, and stays 1 until reset.
- R8: While `window_done` is 1, `event_count` holds even if events keep arriving.
- R9: A synchronous active-high `rst` clears `event_count`, the timer, `window_done` and `obs_event`, and reopens the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge for launch, retiming and counting; falling edge for the catching register |
| rst | input | 1 | Synchronous active-high reset |
| data_async | input | 1 | Asynchronous data under test |
| force_flip | input | 1 | Test input: inverts the value stored by the catching register on the falling edge |
| event_count | output | CNT_W | Saturating count of events inside the window |
| window_done | output | 1 | Sticky flag: the measurement window has closed |
| obs_event | output | 1 | Registered compare of the two capture paths |

## Verification
Real settling failures cannot occur in a clean register model. The bench therefore creates disagreements with `force_flip`, which it drives between edges so that exactly one falling edge sees each forced level. It also toggles `data_async` at random cycles with the force held low, which shows that an honest input alone never counts. The hardest corner is the window boundary. The bench schedules one forced pulse so that its count lands on the last open edge and a second so that it lands one edge later. It uses a shortened window to reach that boundary.

// File: rtl/mh_pkg.sv
package mh_pkg;
  // Both capture paths, aligned to the rising edge.
  typedef struct packed {
    logic same_edge;
    logic half_period;
  } mh_pair_t;
endpackage

// File: rtl/mh_capture.sv
module mh_capture (
  input  logic clk,
  input  logic rst,
  input  logic data_async,
  input  logic force_flip,
  output logic mismatch_o
);
  import mh_pkg::*;

  logic     launch_q;
  logic     catch_fall_q;
  mh_pair_t pair_q;
  logic     mism_q;

  // Launch stage and the same-edge copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      launch_q         <= 1'b0;
      pair_q.same_edge <= 1'b0;
    end else begin
      launch_q         <= data_async;
      pair_q.same_edge <= launch_q;
    end
  end

  // Catching stage on the falling edge; the test input can invert it.
  always_ff @(negedge clk) begin
    if (rst) catch_fall_q <= 1'b0;
    else     catch_fall_q <= launch_q ^ force_flip;
  end

  // Bring the half-period sample back onto the rising edge, then compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q.half_period <= 1'b0;
      mism_q             <= 1'b0;
    end else begin
      pair_q.half_period <= catch_fall_q;
      mism_q             <= pair_q.same_edge ^ pair_q.half_period;
    end
  end

  assign mismatch_o = mism_q;

  // R3: a compare pulse needs an aligned disagreement in the cycle before.
  p_pulse_origin_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mism_q) |-> $past(pair_q.same_edge) != $past(pair_q.half_period));
endmodule

// File: rtl/mh_window_timer.sv
module mh_window_timer #(
  parameter int unsigned WINDOW_LEN = 32'd1 << 30
) (
  input  logic clk,
  input  logic rst,
  output logic done_o
);
  localparam int unsigned TMR_W = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(WINDOW_LEN - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (tmr_q == LAST) done_q <= 1'b1;
      else               tmr_q  <= tmr_q + 1'b1;
    end
  end

  assign done_o = done_q;

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  p_timer_parked_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> $stable(tmr_q));
endmodule

// File: rtl/mh_event_counter.sv
module mh_event_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                                   cnt_q <= '0;
    else if (en_i && evt_i && (cnt_q != FULL)) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> $stable(cnt_q));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL) |=> (cnt_q == FULL));
endmodule

// File: rtl/metastab_harness.sv
module metastab_harness #(
  parameter int          CNT_W      = 20,
  parameter int unsigned WINDOW_LEN = 32'd1 << 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_async,
  input  logic             force_flip,
  output logic [CNT_W-1:0] event_count,
  output logic             window_done,
  output logic             obs_event
);
  logic mism;
  logic done;

  mh_capture u_capture (
    .clk        (clk),
    .rst        (rst),
    .data_async (data_async),
    .force_flip (force_flip),
    .mismatch_o (mism)
  );

  mh_window_timer #(.WINDOW_LEN(WINDOW_LEN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .done_o (done)
  );

  mh_event_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .en_i    (!done),
    .evt_i   (mism),
    .count_o (event_count)
  );

  assign window_done = done;
  assign obs_event   = mism;

  p_frozen_after_window_r8: assert property (@(posedge clk) disable iff (rst)
    window_done |=> $stable(event_count));
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (event_count == '0) && !window_done && !obs_event);
endmodule

// File: tb/tb_metastab_harness.sv
`timescale 1ns/1ps
module tb_metastab_harness;
  localparam int          CNT_W = 5;
  localparam int unsigned WIN   = 200;
  localparam int          FULL  = (1 << CNT_W) - 1;

  localparam logic [7:0] VEC_PAT [4] = '{8'b0000_0001, 8'b1010_1010, 8'b1111_0000, 8'b0000_0000};
  localparam int         VEC_ADD [4] = '{1, 4, 4, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_async = 1'b0;
  logic force_flip = 1'b0;
  logic [CNT_W-1:0] event_count;
  logic window_done;
  logic obs_event;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  metastab_harness #(.CNT_W(CNT_W), .WINDOW_LEN(WIN)) dut (
    .clk(clk), .rst(rst), .data_async(data_async), .force_flip(force_flip),
    .event_count(event_count), .window_done(window_done), .obs_event(obs_event)
  );

  task automatic tick();
    @(posedge clk);
    if (rst) edges = 0; else edges++;
    #5;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at edge %0d", req, act, exp, edges);
    end
  endtask

  task automatic jiggle();
    if ($urandom_range(0, 2) == 0) data_async = ~data_async;
  endtask

  task automatic do_reset();
    rst = 1'b1; force_flip = 1'b0;
    tick(); tick();
    rst = 1'b0;
    exp_cnt = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state
    check("R9 count", int'(event_count), 0);
    check("R9 done", int'(window_done), 0);
    check("R9 obs", int'(obs_event), 0);

    // R2 / R4: table of force patterns with random data underneath
    for (int v = 0; v < 4; v++) begin
      for (int b = 0; b < 8; b++) begin
        force_flip = VEC_PAT[v][b];
        jiggle();
        tick();
      end
      force_flip = 1'b0;
      for (int w = 0; w < 4; w++) tick();
      exp_cnt += VEC_ADD[v];
      check("R2 R4 pattern count", int'(event_count), exp_cnt);
    end

    // R1: random toggling alone never counts
    for (int i = 0; i < 30; i++) begin
      jiggle();
      tick();
      if (obs_event) check("R1 obs quiet", 1, 0);
    end
    check("R1 count unchanged", int'(event_count), exp_cnt);

    // R3: single pulse timing on the observation pin
    force_flip = 1'b1; tick(); force_flip = 1'b0;
    check("R3 obs after k+1", int'(obs_event), 0);
    tick();
    check("R3 obs after k+2", int'(obs_event), 1);
    check("R4 count not yet", int'(event_count), exp_cnt);
    tick();
    exp_cnt++;
    check("R3 obs after k+3", int'(obs_event), 0);
    check("R4 count after k+3", int'(event_count), exp_cnt);

    // R5: saturation
    force_flip = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    force_flip = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check("R5 saturated", int'(event_count), FULL);

    // R9: reset mid-run clears and reopens
    do_reset();
    check("R9 count cleared", int'(event_count), 0);
    check("R9 done cleared", int'(window_done), 0);

    // Three events early in the new window
    for (int i = 0; i < 3; i++) begin
      force_flip = 1'b1; tick(); force_flip = 1'b0; tick();
    end
    for (int i = 0; i < 4; i++) tick();
    exp_cnt = 3;
    check("R4 count after reset", int'(event_count), exp_cnt);

    // R6: boundary pulses land on edges WIN and WIN+1
    while (edges < int'(WIN) - 3) tick();
    force_flip = 1'b1; tick(); tick(); force_flip = 1'b0;
    exp_cnt++;
    while (edges < int'(WIN) - 1) tick();
    check("R7 done low before last edge", int'(window_done), 0);
    tick();
    check("R7 done at last edge", int'(window_done), 1);
    tick(); tick();
    check("R6 boundary count", int'(event_count), exp_cnt);

    // R8: frozen after window; R7 sticky
    force_flip = 1'b1;
    for (int i = 0; i < 6; i++) tick();
    force_flip = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check("R8 frozen count", int'(event_count), exp_cnt);
    check("R7 done sticky", int'(window_done), 1);

    do_reset();
    check("R9 reopen done", int'(window_done), 0);
    check("R9 reopen count", int'(event_count), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule